// File: doc/BRIEF.md
# Two-Bank Indirect Configuration Register Port

This block gives a host a narrow window into fourteen configuration registers through a pair of ports. A byte-wide pointer picks one of two banks (one per disk channel) and one of seven register slots inside that bank. A word-wide data port then reads or writes the chosen slot. When the pointer's advance bit is set, each data-port access steps the slot number, so a whole bank can be loaded or dumped with repeated data accesses and a single pointer write.

Each bank holds the command-block base, the control-block base, a general control byte, a 10-bit read-ahead count with its enable and a FIFO-clear strobe, and two timing bytes. All of them come up at fixed defaults. Their fields are decoded onto dedicated output ports for the channel logic. The pointer also carries three bus-option bits that are brought out directly. The address decoding that steers host cycles to the two ports lives outside this block.

Top module: `cfg_ptr_regs`

## Requirements
- R1: After reset the pointer reads 0x50. Each bank reads back as follows: slot 0 = 0x01F0 (bank 0) or 0x0170 (bank 1), slot 1 = 0x0001, slot 4 = 0x03F6 (bank 0) or 0x0376 (bank 1), slot 5 = 0x00F5, slot 6 = 0x00DE. The read-ahead count and its enable are 0.
- R2: Pointer bits 2:0 give the slot and bit 3 the bank (0 = bank 0, 1 = bank 1). A data write changes only the addressed slot of the addressed bank.
- R3: With pointer bit 7 set, every data read or data write advances pointer bits 2:0 by one. With bit 7 clear, a data access leaves the pointer unchanged.
- R4: Advancing from slot 6 or slot 7 gives slot 0. The bank bit and the upper pointer bits are kept.
- R5: Slot 7 reads as 0, and a write to slot 7 changes no register and no output.
- R6: Slots 2 and 3, pointer bit 5 and bit 2 of slot 1 are write-only and read as 0.
- R7: The read-ahead count is {slot 3 bits 1:0, slot 2 bits 7:0}. Slot 3 bit 7 drives the read-ahead enable.
- R8: Writing slot 3 with bit 6 set raises that bank's FIFO-clear output for exactly the one cycle after the write.
- R9: Slot 1 bits map to outputs as follows: bit 7 DMA enable, bit 6 drive reset, bit 5 ready-wait enable, bit 4 8-bit data port, bit 3 active-low interrupt, bit 1 bus-master mode, bit 0 I/O enable.
- R10: If a pointer write and a data access fall in the same cycle, the access uses the old pointer. The pointer then takes the written value with no advance.
- R11: Slots 0 and 4 hold 16 bits. The other slots keep only data bits 7:0 and read with bits 15:8 as 0.
- R12: Pointer bit 6 drives the posted-write wait output, bit 5 the burst-disable output and bit 4 the medium select-timing output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ptr_we | input | 1 | Pointer write strobe |
| ptr_wdata | input | 8 | Pointer write value |
| ptr_rdata | output | 8 | Pointer read value (bit 5 reads 0) |
| dat_we | input | 1 | Data-port write strobe |
| dat_re | input | 1 | Data-port read strobe |
| dat_wdata | input | 16 | Data-port write value |
| dat_rdata | output | 16 | Value of the slot the pointer selects |
| post_wait_o | output | 1 | One-wait-state posted write select |
| burst_dis_o | output | 1 | Master burst disable |
| devsel_med_o | output | 1 | Medium select-timing |
| cmd_base_o | output | 32 | Command-block bases, bank 1 in bits 31:16 |
| ctl_base_o | output | 32 | Control-block bases, bank 1 in bits 31:16 |
| dma_en_o | output | 2 | DMA enable per bank |
| drv_rst_o | output | 2 | Drive reset per bank |
| rdy_en_o | output | 2 | Ready-wait enable per bank |
| narrow_o | output | 2 | 8-bit data port per bank |
| irq_low_o | output | 2 | Active-low interrupt per bank |
| bm_en_o | output | 2 | Bus-master mode per bank |
| io_en_o | output | 2 | I/O enable per bank |
| ra_count_o | output | 20 | Read-ahead counts, bank 1 in bits 19:10 |
| ra_en_o | output | 2 | Read-ahead enable per bank |
| fifo_clr_o | output | 2 | FIFO-clear pulse per bank |
| dtim_o | output | 16 | Data timing bytes, bank 1 in bits 15:8 |
| ctim_o | output | 16 | Command timing bytes, bank 1 in bits 15:8 |

## Verification
Two functions can land in the same cycle: a pointer write, and the pointer advance that a data access triggers. The bench raises the pointer strobe and a data strobe in one cycle, once with a write and once with a read, with the advance bit set in the old pointer. It checks that the data went to, or came from, the slot the old pointer named. It also checks that the pointer then reads back the written value and not that value plus one.

// File: rtl/cfg_ptr_regs.sv
module cfg_ptr_regs #(
  parameter logic [15:0] CMD0_RST = 16'h01F0,
  parameter logic [15:0] CMD1_RST = 16'h0170,
  parameter logic [15:0] CTL0_RST = 16'h03F6,
  parameter logic [15:0] CTL1_RST = 16'h0376,
  parameter logic [7:0]  GEN_RST  = 8'h01,
  parameter logic [7:0]  DTIM_RST = 8'hF5,
  parameter logic [7:0]  CTIM_RST = 8'hDE,
  parameter logic [7:0]  PTR_RST  = 8'h50,
  parameter int          RA_W     = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_we,
  input  logic [7:0]       ptr_wdata,
  output logic [7:0]       ptr_rdata,
  input  logic             dat_we,
  input  logic             dat_re,
  input  logic [15:0]      dat_wdata,
  output logic [15:0]      dat_rdata,
  output logic             post_wait_o,
  output logic             burst_dis_o,
  output logic             devsel_med_o,
  output logic [31:0]      cmd_base_o,
  output logic [31:0]      ctl_base_o,
  output logic [1:0]       dma_en_o,
  output logic [1:0]       drv_rst_o,
  output logic [1:0]       rdy_en_o,
  output logic [1:0]       narrow_o,
  output logic [1:0]       irq_low_o,
  output logic [1:0]       bm_en_o,
  output logic [1:0]       io_en_o,
  output logic [2*RA_W-1:0] ra_count_o,
  output logic [1:0]       ra_en_o,
  output logic [1:0]       fifo_clr_o,
  output logic [15:0]      dtim_o,
  output logic [15:0]      ctim_o
);
  localparam int HI_W = RA_W - 8;
  localparam logic [7:0] GEN_WMASK = 8'hFB;
  localparam logic [7:0] PTR_RMASK = 8'hDF;

  logic [7:0]      ptr;
  logic [15:0]     cmd   [2];
  logic [15:0]     ctl   [2];
  logic [7:0]      gen   [2];
  logic [7:0]      ra_lo [2];
  logic [HI_W-1:0] ra_hi [2];
  logic [1:0]      ra_en;
  logic [7:0]      dtim  [2];
  logic [7:0]      ctim  [2];
  logic [1:0]      fclr;

  logic [2:0] idx;
  logic       bank;
  logic       access;
  logic [2:0] idx_next;

  assign idx      = ptr[2:0];
  assign bank     = ptr[3];
  assign access   = dat_we | dat_re;
  assign idx_next = (idx >= 3'd6) ? 3'd0 : idx + 3'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr    <= PTR_RST;
      cmd[0] <= CMD0_RST;
      cmd[1] <= CMD1_RST;
      ctl[0] <= CTL0_RST;
      ctl[1] <= CTL1_RST;
      for (int b = 0; b < 2; b++) begin
        gen[b]   <= GEN_RST;
        ra_lo[b] <= '0;
        ra_hi[b] <= '0;
        dtim[b]  <= DTIM_RST;
        ctim[b]  <= CTIM_RST;
      end
      ra_en <= '0;
      fclr  <= '0;
    end else begin
      fclr <= '0;
      if (dat_we) begin
        case (idx)
          3'd0: cmd[bank]   <= dat_wdata;
          3'd1: gen[bank]   <= dat_wdata[7:0] & GEN_WMASK;
          3'd2: ra_lo[bank] <= dat_wdata[7:0];
          3'd3: begin
            ra_hi[bank] <= dat_wdata[HI_W-1:0];
            ra_en[bank] <= dat_wdata[7];
            fclr[bank]  <= dat_wdata[6];
          end
          3'd4: ctl[bank]   <= dat_wdata;
          3'd5: dtim[bank]  <= dat_wdata[7:0];
          3'd6: ctim[bank]  <= dat_wdata[7:0];
          default: ;
        endcase
      end
      if (ptr_we)
        ptr <= ptr_wdata;
      else if (access && ptr[7])
        ptr[2:0] <= idx_next;
    end
  end

  always_comb begin
    case (idx)
      3'd0:    dat_rdata = cmd[bank];
      3'd1:    dat_rdata = {8'h00, gen[bank]};
      3'd4:    dat_rdata = ctl[bank];
      3'd5:    dat_rdata = {8'h00, dtim[bank]};
      3'd6:    dat_rdata = {8'h00, ctim[bank]};
      default: dat_rdata = 16'h0000;
    endcase
  end

  assign ptr_rdata    = ptr & PTR_RMASK;
  assign post_wait_o  = ptr[6];
  assign burst_dis_o  = ptr[5];
  assign devsel_med_o = ptr[4];
  assign ra_en_o      = ra_en;
  assign fifo_clr_o   = fclr;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    assign cmd_base_o[16*b +: 16]   = cmd[b];
    assign ctl_base_o[16*b +: 16]   = ctl[b];
    assign dma_en_o[b]              = gen[b][7];
    assign drv_rst_o[b]             = gen[b][6];
    assign rdy_en_o[b]              = gen[b][5];
    assign narrow_o[b]              = gen[b][4];
    assign irq_low_o[b]             = gen[b][3];
    assign bm_en_o[b]               = gen[b][1];
    assign io_en_o[b]               = gen[b][0];
    assign ra_count_o[RA_W*b +: RA_W] = {ra_hi[b], ra_lo[b]};
    assign dtim_o[8*b +: 8]         = dtim[b];
    assign ctim_o[8*b +: 8]         = ctim[b];
  end
endmodule

// File: rtl/cfg_ptr_regs_chk.sv
module cfg_ptr_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ptr_we,
  input logic [7:0]  ptr_wdata,
  input logic [7:0]  ptr_rdata,
  input logic        dat_we,
  input logic        dat_re,
  input logic [15:0] dat_wdata,
  input logic [15:0] dat_rdata,
  input logic [1:0]  fifo_clr_o
);
  // R3
  autoinc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dat_we || dat_re) && !ptr_we && ptr_rdata[7] && ptr_rdata[2:0] < 3'd6)
    |=> ptr_rdata[2:0] == $past(ptr_rdata[2:0]) + 3'd1);

  // R3
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ptr_we && !ptr_rdata[7]) |=> $stable(ptr_rdata));

  // R4
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((dat_we || dat_re) && !ptr_we && ptr_rdata[7] && ptr_rdata[2:0] >= 3'd6)
    |=> ptr_rdata[2:0] == 3'd0 && ptr_rdata[7:3] == $past(ptr_rdata[7:3]));

  // R5
  slot7_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_rdata[2:0] == 3'd7) |-> dat_rdata == 16'h0000);

  // R6
  wo_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr_rdata[2:1] == 2'b01) |-> dat_rdata == 16'h0000);

  // R8
  fifo_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(fifo_clr_o) != 0 |->
      $past(dat_we && ptr_rdata[2:0] == 3'd3 && dat_wdata[6]) && $onehot0(fifo_clr_o));

  // R10
  ptr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_we |=> ptr_rdata == ($past(ptr_wdata) & 8'hDF));
endmodule

bind cfg_ptr_regs cfg_ptr_regs_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ptr_we(ptr_we), .ptr_wdata(ptr_wdata),
  .ptr_rdata(ptr_rdata), .dat_we(dat_we), .dat_re(dat_re),
  .dat_wdata(dat_wdata), .dat_rdata(dat_rdata), .fifo_clr_o(fifo_clr_o)
);

// File: tb/cfg_ptr_regs_tb_top.sv
`timescale 1ns/1ps
module cfg_ptr_regs_tb_top;
  logic clk = 0, rst_n = 0;
  logic ptr_we = 0, dat_we = 0, dat_re = 0;
  logic [7:0] ptr_wdata = 0, ptr_rdata;
  logic [15:0] dat_wdata = 0, dat_rdata;
  logic post_wait_o, burst_dis_o, devsel_med_o;
  logic [31:0] cmd_base_o, ctl_base_o;
  logic [1:0] dma_en_o, drv_rst_o, rdy_en_o, narrow_o, irq_low_o, bm_en_o, io_en_o;
  logic [19:0] ra_count_o;
  logic [1:0] ra_en_o, fifo_clr_o;
  logic [15:0] dtim_o, ctim_o;

  int vecs = 0, errs = 0;
  logic [15:0] exp_q[$];
  string req_q[$];

  always #2.5 clk = ~clk;

  cfg_ptr_regs dut_i (.*);

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && dat_re) begin
    if (exp_q.size() == 0) chk(32'hDEAD, 32'h0, "unexpected read");
    else chk({16'h0, dat_rdata}, {16'h0, exp_q.pop_front()}, req_q.pop_front());
  end

  task automatic wptr(input logic [7:0] v);
    @(posedge clk); #1 ptr_we = 1; ptr_wdata = v;
    @(posedge clk); #1 ptr_we = 0;
  endtask
  task automatic wdat(input logic [15:0] v);
    @(posedge clk); #1 dat_we = 1; dat_wdata = v;
    @(posedge clk); #1 dat_we = 0;
  endtask
  task automatic rdat(input logic [15:0] e, input string req);
    exp_q.push_back(e); req_q.push_back(req);
    @(posedge clk); #1 dat_re = 1;
    @(posedge clk); #1 dat_re = 0;
  endtask

  logic [255:0] snap;
  function automatic logic [255:0] outs();
    return {cmd_base_o, ctl_base_o, dma_en_o, drv_rst_o, rdy_en_o, narrow_o,
            irq_low_o, bm_en_o, io_en_o, ra_count_o, ra_en_o, fifo_clr_o, dtim_o, ctim_o};
  endfunction

  initial begin
    #1000000;
    errs++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    chk(ptr_rdata, 8'h50, "R1 pointer reset");
    chk({post_wait_o, burst_dis_o, devsel_med_o}, 3'b101, "R12 reset options");
    chk(ra_count_o, 0, "R1 read-ahead reset");
    // R1 R3 R4 R6 bank 0 dump with autoincrement
    wptr(8'h80);
    rdat(16'h01F0, "R1 b0 s0"); rdat(16'h0001, "R1 b0 s1"); rdat(16'h0000, "R6 b0 s2");
    rdat(16'h0000, "R6 b0 s3"); rdat(16'h03F6, "R1 b0 s4"); rdat(16'h00F5, "R1 b0 s5");
    rdat(16'h00DE, "R1 b0 s6");
    chk(ptr_rdata, 8'h80, "R4 wrap after slot 6");
    wptr(8'h88);
    rdat(16'h0170, "R1 b1 s0"); rdat(16'h0001, "R1 b1 s1"); rdat(16'h0000, "R6 b1 s2");
    rdat(16'h0000, "R6 b1 s3"); rdat(16'h0376, "R1 b1 s4"); rdat(16'h00F5, "R1 b1 s5");
    rdat(16'h00DE, "R1 b1 s6");
    chk(ptr_rdata, 8'h88, "R4 wrap keeps bank");
    // R3 no advance
    wptr(8'h04);
    rdat(16'h03F6, "R3 hold read 1"); rdat(16'h03F6, "R3 hold read 2");
    chk(ptr_rdata, 8'h04, "R3 pointer unchanged");
    // R2 R11 bank isolation
    wptr(8'h08); wdat(16'hABCD);
    rdat(16'hABCD, "R2 b1 s0 written");
    wptr(8'h00); rdat(16'h01F0, "R2 b0 s0 untouched");
    chk(cmd_base_o, 32'hABCD01F0, "R2 cmd base outputs");
    // R9 R6 R11 general byte
    wptr(8'h01); wdat(16'hFFFF);
    rdat(16'h00FB, "R6 R11 slot1 readback");
    chk({dma_en_o[0], drv_rst_o[0], rdy_en_o[0], narrow_o[0], irq_low_o[0], bm_en_o[0], io_en_o[0]},
        7'h7F, "R9 all set");
    chk({dma_en_o[1], drv_rst_o[1], rdy_en_o[1], narrow_o[1], irq_low_o[1], bm_en_o[1], io_en_o[1]},
        7'h01, "R9 other bank");
    wdat(16'h00A2);
    chk({dma_en_o[0], drv_rst_o[0], rdy_en_o[0], narrow_o[0], irq_low_o[0], bm_en_o[0], io_en_o[0]},
        7'b1010010, "R9 pattern A2");
    // R7 R8 read-ahead
    wptr(8'h0A); wdat(16'h005A);
    wptr(8'h0B); wdat(16'h00C3);
    chk(fifo_clr_o, 2'b10, "R8 strobe high");
    chk(ra_count_o, {10'h35A, 10'h000}, "R7 count");
    chk(ra_en_o, 2'b10, "R7 enable");
    @(posedge clk); #1 chk(fifo_clr_o, 2'b00, "R8 strobe self-clears");
    rdat(16'h0000, "R6 slot3 reads zero");
    wdat(16'h0001);
    chk(ra_count_o, {10'h15A, 10'h000}, "R7 count high bits");
    chk({ra_en_o, fifo_clr_o}, 4'b0000, "R7 R8 enable off no strobe");
    // R4 R11 timing bytes with wrap on write
    wptr(8'h85); wdat(16'h1234);
    chk(ptr_rdata, 8'h86, "R3 advance on write");
    wdat(16'h00FF);
    chk(ptr_rdata, 8'h80, "R4 wrap on write");
    chk({dtim_o[7:0], ctim_o[7:0]}, 16'h34FF, "R11 timing bytes");
    // R5 slot 7
    snap = outs();
    wptr(8'h07); rdat(16'h0000, "R5 slot7 read");
    wdat(16'hFFFF);
    chk(ptr_rdata, 8'h07, "R5 pointer");
    vecs++; if (outs() !== snap) begin errs++; $display("FAIL R5: actual %h expected %h", outs(), snap); end
    wptr(8'h8F); rdat(16'h0000, "R5 slot7 b1");
    chk(ptr_rdata, 8'h88, "R4 wrap from slot 7");
    // R12 R6 pointer options
    wptr(8'h20);
    chk(ptr_rdata, 8'h00, "R6 bit5 reads zero");
    chk({post_wait_o, burst_dis_o, devsel_med_o}, 3'b010, "R12 options");
    // R10 collision with write
    wptr(8'h80);
    @(posedge clk); #1 ptr_we = 1; ptr_wdata = 8'h85; dat_we = 1; dat_wdata = 16'h0777;
    @(posedge clk); #1 ptr_we = 0; dat_we = 0;
    chk(ptr_rdata, 8'h85, "R10 pointer wins");
    chk(cmd_base_o[15:0], 16'h0777, "R10 write used old pointer");
    rdat(16'h0034, "R10 new slot read");
    // R10 collision with read
    wptr(8'h80);
    exp_q.push_back(16'h0777); req_q.push_back("R10 read used old pointer");
    @(posedge clk); #1 ptr_we = 1; ptr_wdata = 8'h0C; dat_re = 1;
    @(posedge clk); #1 ptr_we = 0; dat_re = 0;
    chk(ptr_rdata, 8'h0C, "R10 pointer after read collision");
    repeat (2) @(posedge clk);
    chk(exp_q.size(), 0, "scoreboard drained");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule